// File: doc/BRIEF.md
# Receive FIFO with Per-Byte Status

This block buffers bytes coming out of an infrared deframer. Every byte is stored with three tag bits: a CRC failure, an overrun, and a frame-end mark. Because the tags sit in the same slot as the byte, errors and frame boundaries stay aligned with the data they belong to. The read side behaves like a register pair. Software reads a status word that describes the entry at the head of the queue, and then pops that entry's data byte. Popping moves on to the next entry, so the status has to be read before the data.

A small control register holds the receive enable, the interrupt enable and a two-bit trigger code. The trigger code sets the fill level at which a service request is raised. A separate end/error output looks only at the head entry. It is high while the head is marked bad or ends a frame, so software can stop at the right byte rather than at a fill count. Two sticky event bits, framing error and receiver abort, hold until software clears them with a write-one-to-clear mask.

Top module: `irx_stat_fifo`

## Requirements
- R1: After reset the FIFO is empty, the control register is zero (receiver off, interrupt off, trigger code 0), both sticky bits are clear, `svc_req` and `end_err` are low, and `stat_word` is zero except that bit 1 follows `tx_not_full`.
- R2: Accepted bytes come out in write order, each with its own tags. `stat_word` bit 2 is the head's CRC error, bit 3 its overrun, and bit 4 its frame end. A pulse on `rd_pop` moves on to the next entry. While the FIFO is empty, bits 2 to 4 read 0.
- R3: `stat_word` bit 0 is high exactly when the FIFO holds at least one entry. Bit 1 mirrors the `tx_not_full` input.
- R4: `end_err` and `stat_word` bit 7 are high exactly when the FIFO is not empty and the head entry has a CRC error, an overrun or a frame end.
- R5: The trigger code selects the fill threshold as follows: 0 selects 8, 1 selects 16, 2 selects 32, and 3 also selects 32. `svc_req` is high while the interrupt enable is set and the fill level is at or above the threshold.
- R6: The FIFO holds 64 entries. A write while it is full and not popping drops the incoming byte and sets the overrun tag of the most recently stored entry.
- R7: While the receive enable is 0, incoming writes are ignored, and popping still drains the leftover entries.
- R8: A pop of an empty FIFO has no effect, and `rd_data` reads 0 while the FIFO is empty.
- R9: Pulses on `ev_frame_err` and `ev_abort` set `stat_word` bits 5 and 6. Each bit stays set until a `clr_we` cycle has the matching `clr_mask` bit at 1 (mask bit 0 for bit 5, mask bit 1 for bit 6). A set and a clear in the same cycle leave the bit set.
- R10: A `ctl_we` cycle loads the control register from `ctl_wdata`: bit 0 is the receive enable, bit 1 the interrupt enable, and bits 3:2 the trigger code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Deframer byte strobe |
| wr_data | input | DATA_W | Deframer byte |
| wr_crc_err | input | 1 | CRC failure tag for this byte |
| wr_ovr | input | 1 | Overrun tag for this byte |
| wr_eof | input | 1 | Frame-end tag for this byte |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | {trigger[1:0], irq enable, rx enable} |
| ev_frame_err | input | 1 | Framing-error event pulse |
| ev_abort | input | 1 | Receiver-abort event pulse |
| clr_we | input | 1 | Write-one-to-clear strobe for sticky bits |
| clr_mask | input | 2 | Bit 0 clears framing error, bit 1 clears abort |
| tx_not_full | input | 1 | Transmit side room flag, shown in status |
| rd_pop | input | 1 | Pop the head entry |
| rd_data | output | DATA_W | Head data byte, 0 when empty |
| stat_word | output | 8 | Status of head entry and block |
| svc_req | output | 1 | Fill-threshold service request |
| end_err | output | 1 | Head entry is bad or ends a frame |

## Verification
The bench sweeps every trigger code across fill levels from 0 to 40 and checks the level at which the service request rises. An off-by-one compare would show up as a request one byte early or late, and a wrong decode would show up as a request at the wrong power of two. It fills the queue to 64 and keeps writing. A design that overwrote the head, or marked the wrong slot, would show a corrupted first byte or a clean last entry. It also pops while empty and then checks that the next byte still comes out intact, which catches pointers that move when they should not. The sticky bits are checked against the opposite mask bit and against a set and a clear in the same cycle.

// File: rtl/irx_pkg.sv
package irx_pkg;
   typedef struct packed {
      logic crc;
      logic ovr;
      logic eof;
   } rx_tag_t;

   typedef enum logic [1:0] {
      TRIG_LO  = 2'd0,
      TRIG_MID = 2'd1,
      TRIG_HI  = 2'd2,
      TRIG_RSV = 2'd3
   } trig_sel_e;

   localparam int STAT_W   = 8;
   localparam int SB_RNE   = 0;
   localparam int SB_TNF   = 1;
   localparam int SB_CRC   = 2;
   localparam int SB_OVR   = 3;
   localparam int SB_EOF   = 4;
   localparam int SB_FRE   = 5;
   localparam int SB_RAB   = 6;
   localparam int SB_EOE   = 7;
endpackage

// File: rtl/irx_fifo_core.sv
module irx_fifo_core
   import irx_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  rx_tag_t           push_tag,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output rx_tag_t           head_tag,
   output logic [CW-1:0]     level,
   output logic              empty,
   output logic              full
);
   if ((1 << AW) != DEPTH) begin : g_depth_chk
      $error("irx_fifo_core: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] dmem [DEPTH];
   rx_tag_t           tmem [DEPTH];
   logic [AW-1:0]     wp, rp;
   logic              do_pop, accept, mark_ovr;
   logic [AW-1:0]     last_wp;

   assign empty    = (level == '0);
   assign full     = (level == CW'(DEPTH));
   assign do_pop   = pop && !empty;
   assign accept   = push && (!full || do_pop);
   assign mark_ovr = push && full && !do_pop;
   assign last_wp  = wp - AW'(1);

   always_ff @(posedge clk) begin
      if (accept) begin
         dmem[wp] <= push_data;
         tmem[wp] <= push_tag;
      end else if (mark_ovr) begin
         tmem[last_wp].ovr <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (accept) wp <= wp + AW'(1);
         if (do_pop) rp <= rp + AW'(1);
         case ({accept, do_pop})
            2'b10:   level <= level + CW'(1);
            2'b01:   level <= level - CW'(1);
            default: level <= level;
         endcase
      end
   end

   assign head_data = empty ? '0 : dmem[rp];
   assign head_tag  = empty ? '0 : tmem[rp];
endmodule

// File: rtl/irx_svc_gen.sv
module irx_svc_gen
   import irx_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int BASE_TRIG = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic [CW-1:0] level,
   input  logic [1:0]    trig,
   input  logic          irq_en,
   output logic          svc_req
);
   localparam int TOP_TRIG = BASE_TRIG * 4;

   if (TOP_TRIG > DEPTH) begin : g_trig_chk
      $error("irx_svc_gen: largest threshold exceeds DEPTH");
   end

   logic [CW-1:0] thr;

   always_comb begin
      case (trig_sel_e'(trig))
         TRIG_LO:  thr = CW'(BASE_TRIG);
         TRIG_MID: thr = CW'(BASE_TRIG * 2);
         default:  thr = CW'(TOP_TRIG);
      endcase
   end

   assign svc_req = irq_en && (level >= thr);
endmodule

// File: rtl/irx_stat_fifo.sv
module irx_stat_fifo
   import irx_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int DATA_W    = 8,
   parameter int BASE_TRIG = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_crc_err,
   input  logic              wr_ovr,
   input  logic              wr_eof,
   input  logic              ctl_we,
   input  logic [3:0]        ctl_wdata,
   input  logic              ev_frame_err,
   input  logic              ev_abort,
   input  logic              clr_we,
   input  logic [1:0]        clr_mask,
   input  logic              tx_not_full,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic [STAT_W-1:0] stat_word,
   output logic              svc_req,
   output logic              end_err
);
   logic          rx_en, irq_en;
   logic [1:0]    trig;
   logic          fre_q, rab_q;
   rx_tag_t       in_tag, hd_tag;
   logic [CW-1:0] level;
   logic          empty, full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en  <= 1'b0;
         irq_en <= 1'b0;
         trig   <= 2'd0;
      end else if (ctl_we) begin
         rx_en  <= ctl_wdata[0];
         irq_en <= ctl_wdata[1];
         trig   <= ctl_wdata[3:2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fre_q <= 1'b0;
         rab_q <= 1'b0;
      end else begin
         fre_q <= ev_frame_err || (fre_q && !(clr_we && clr_mask[0]));
         rab_q <= ev_abort     || (rab_q && !(clr_we && clr_mask[1]));
      end
   end

   assign in_tag = '{crc: wr_crc_err, ovr: wr_ovr, eof: wr_eof};

   irx_fifo_core #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_valid && rx_en),
      .push_data (wr_data),
      .push_tag  (in_tag),
      .pop       (rd_pop),
      .head_data (rd_data),
      .head_tag  (hd_tag),
      .level     (level),
      .empty     (empty),
      .full      (full)
   );

   irx_svc_gen #(.DEPTH(DEPTH), .BASE_TRIG(BASE_TRIG)) u_svc (
      .level   (level),
      .trig    (trig),
      .irq_en  (irq_en),
      .svc_req (svc_req)
   );

   assign end_err = hd_tag.crc || hd_tag.ovr || hd_tag.eof;

   always_comb begin
      stat_word         = '0;
      stat_word[SB_RNE] = !empty;
      stat_word[SB_TNF] = tx_not_full;
      stat_word[SB_CRC] = hd_tag.crc;
      stat_word[SB_OVR] = hd_tag.ovr;
      stat_word[SB_EOF] = hd_tag.eof;
      stat_word[SB_FRE] = fre_q;
      stat_word[SB_RAB] = rab_q;
      stat_word[SB_EOE] = end_err;
   end
endmodule

// File: rtl/irx_stat_fifo_chk.sv
module irx_stat_fifo_chk #(
   parameter int DEPTH     = 64,
   parameter int DATA_W    = 8,
   parameter int BASE_TRIG = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        stat_word,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_pop,
   input logic              wr_valid,
   input logic              svc_req,
   input logic              end_err,
   input logic [CW-1:0]     level,
   input logic              rx_en,
   input logic              clr_we,
   input logic [1:0]        clr_mask,
   input logic              ev_frame_err
);
   assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));

   assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_word[0] |-> (rd_data == '0));

   assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_word[0] && !wr_valid) |=> !stat_word[0]);

   assert_eoe_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      end_err |-> stat_word[0]);

   assert_svc_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |-> (level >= CW'(BASE_TRIG)));

   assert_rx_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !rd_pop) |=> $stable(level));

   assert_sticky_fre_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_word[5] && !(clr_we && clr_mask[0])) |=> stat_word[5]);

   assert_sticky_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_frame_err |=> stat_word[5]);
endmodule

bind irx_stat_fifo irx_stat_fifo_chk #(
   .DEPTH(DEPTH), .DATA_W(DATA_W), .BASE_TRIG(BASE_TRIG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stat_word    (stat_word),
   .rd_data      (rd_data),
   .rd_pop       (rd_pop),
   .wr_valid     (wr_valid),
   .svc_req      (svc_req),
   .end_err      (end_err),
   .level        (level),
   .rx_en        (rx_en),
   .clr_we       (clr_we),
   .clr_mask     (clr_mask),
   .ev_frame_err (ev_frame_err)
);

// File: tb/sim_irx_stat_fifo.sv
module sim_irx_stat_fifo;
   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid = 0, wr_crc_err = 0, wr_ovr = 0, wr_eof = 0;
   logic [7:0] wr_data = 0;
   logic       ctl_we = 0;
   logic [3:0] ctl_wdata = 0;
   logic       ev_frame_err = 0, ev_abort = 0, clr_we = 0;
   logic [1:0] clr_mask = 0;
   logic       tx_not_full = 0, rd_pop = 0;
   logic [7:0] rd_data, stat_word;
   logic       svc_req, end_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [10:0] q [$];
   bit          m_en = 0;

   always #4 clk = ~clk;

   irx_stat_fifo u0 (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_crc_err(wr_crc_err), .wr_ovr(wr_ovr), .wr_eof(wr_eof),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ev_frame_err(ev_frame_err),
      .ev_abort(ev_abort), .clr_we(clr_we), .clr_mask(clr_mask),
      .tx_not_full(tx_not_full), .rd_pop(rd_pop), .rd_data(rd_data),
      .stat_word(stat_word), .svc_req(svc_req), .end_err(end_err)
   );

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_stat(input logic fre, input logic rab);
      logic [7:0] s;
      logic [10:0] h;
      s = '0;
      h = (q.size() > 0) ? q[0] : '0;
      s[0] = q.size() > 0;
      s[1] = tx_not_full;
      s[2] = h[10];
      s[3] = h[9];
      s[4] = h[8];
      s[5] = fre;
      s[6] = rab;
      s[7] = h[10] | h[9] | h[8];
      return s;
   endfunction

   task automatic set_ctl(input logic en, input logic ie, input logic [1:0] tg);
      @(negedge clk);
      ctl_we = 1; ctl_wdata = {tg, ie, en};
      @(negedge clk);
      ctl_we = 0;
      m_en = en;
   endtask

   task automatic push(input logic [7:0] d, input logic c, input logic o, input logic e);
      @(negedge clk);
      wr_valid = 1; wr_data = d; wr_crc_err = c; wr_ovr = o; wr_eof = e;
      @(negedge clk);
      wr_valid = 0; wr_crc_err = 0; wr_ovr = 0; wr_eof = 0;
      if (m_en) begin
         if (q.size() < DEPTH) q.push_back({c, o, e, d});
         else q[q.size()-1][9] = 1'b1;
      end
   endtask

   task automatic pop_chk(input string r);
      @(negedge clk);
      chk({r, " status"}, stat_word, exp_stat(0, 0));
      chk({r, " data"}, rd_data, (q.size() > 0) ? q[0][7:0] : 8'h00);
      chk({r, " end_err"}, end_err, exp_stat(0, 0)[7]);
      rd_pop = 1;
      @(negedge clk);
      rd_pop = 0;
      if (q.size() > 0) void'(q.pop_front());
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int thr;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 stat", stat_word, 8'h00);
      chk("R1 svc", svc_req, 0);
      chk("R1 eoe", end_err, 0);
      chk("R1 data", rd_data, 0);
      // R3 tx_not_full passthrough
      tx_not_full = 1;
      #1 chk("R3 tnf", stat_word, 8'h02);
      // R7/R10 receiver off at reset: writes ignored
      push(8'h5A, 0, 0, 1);
      chk("R7 off ignored", stat_word[0], 0);
      // R5 R10 sweep every trigger code
      for (int tg = 0; tg < 4; tg++) begin
         set_ctl(1, 1, tg[1:0]);
         thr = (tg == 0) ? 8 : (tg == 1) ? 16 : 32;
         for (int n = 1; n <= 40; n++) begin
            push(8'((n * 7 + tg) & 8'hFF), n[0] & n[2], n[1] & n[3], (n % 5) == 0);
            chk($sformatf("R5 trig%0d n%0d", tg, n), svc_req, (n >= thr));
         end
         // R2 R3 R4 drain with status before data
         for (int n = 0; n < 40; n++) pop_chk("R2 drain");
         chk("R3 empty after drain", stat_word[0], 0);
      end
      // R5 interrupt enable gates request
      set_ctl(1, 0, 2'd0);
      for (int n = 0; n < 10; n++) push(8'(n), 0, 0, 0);
      chk("R5 ie off", svc_req, 0);
      for (int n = 0; n < 10; n++) pop_chk("R2 drain ie");
      // R6 fill and overflow
      for (int n = 0; n < DEPTH; n++) push(8'(n + 8'h40), 0, 0, 0);
      chk("R6 full no flag", stat_word[3], 0);
      push(8'hEE, 0, 0, 0);
      push(8'hEF, 1, 0, 1);
      chk("R6 head intact", rd_data, 8'h40);
      for (int n = 0; n < DEPTH; n++) pop_chk("R6 drain");
      chk("R6 empty", stat_word[0], 0);
      // R7 disable with leftovers: drain still works
      for (int n = 0; n < 3; n++) push(8'(n + 8'hA0), 0, 0, n == 2);
      set_ctl(0, 0, 2'd0);
      push(8'hBB, 0, 0, 0);
      for (int n = 0; n < 3; n++) pop_chk("R7 drain");
      chk("R7 empty", stat_word[0], 0);
      // R8 empty pop changes nothing
      @(negedge clk);
      rd_pop = 1;
      @(negedge clk);
      rd_pop = 0;
      chk("R8 empty data", rd_data, 0);
      chk("R8 empty stat", stat_word[0], 0);
      set_ctl(1, 0, 2'd0);
      push(8'h3C, 1, 0, 0);
      pop_chk("R8 after empty pop");
      chk("R8 empty again", stat_word[0], 0);
      // R9 sticky bits
      @(negedge clk);
      ev_frame_err = 1; ev_abort = 1;
      @(negedge clk);
      ev_frame_err = 0; ev_abort = 0;
      chk("R9 set", stat_word[6:5], 2'b11);
      clr_we = 1; clr_mask = 2'b10;
      @(negedge clk);
      clr_we = 0;
      chk("R9 other mask", stat_word[6:5], 2'b01);
      repeat (2) @(negedge clk);
      chk("R9 held", stat_word[6:5], 2'b01);
      clr_we = 1; clr_mask = 2'b01; ev_frame_err = 1;
      @(negedge clk);
      clr_we = 0; ev_frame_err = 0;
      chk("R9 set wins", stat_word[6:5], 2'b01);
      clr_we = 1; clr_mask = 2'b01;
      @(negedge clk);
      clr_we = 0;
      chk("R9 cleared", stat_word[6:5], 2'b00);
      finish_run();
   end
endmodule